// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Controller

This controller runs on the reference clock of a clock synthesizer and produces a signed frequency-offset code. The code can steer a current DAC or a fractional feedback divider. While modulation is active, the code traces a periodic triangle built from linear ramps. The code unit is 0.01 % of the nominal frequency.

Two geometries are available. In centered mode the triangle swings equally above and below nominal. In downward mode it stays at or below nominal. A depth pin selects the shallow or the deep amplitude, and the deep setting is twice the shallow one. A new geometry or depth takes effect only when a triangle period starts, so a ramp is never broken in the middle.

A power-down input forces the code to zero, drops the clock-output enable and restarts the triangle from its start point. A settling flag reports when a programmable wait has elapsed. That wait starts again after power-down release and after any change on the depth pin or the modulation enable.

Top module: `ssc_tri_mod`

## Requirements
- R1: While `rst_n` is low, `offset_code` is 0, `ready` is 0 and `clk_out_en` is 0.
- R2: With the latched geometry centered (`center_sel` = 1), the triangle starts at 0. It climbs to +DEPTH_LO/2, falls to -DEPTH_LO/2 and climbs back to 0. With the latched depth deep (`deep_sel` = 1), every value is doubled, so the peaks are ±DEPTH_LO. The code is two's complement with 1 LSB = 0.01 %.
- R3: With the latched geometry downward (`center_sel` = 0), the triangle starts at 0. It falls to -DEPTH_LO, or -2*DEPTH_LO when deep, and rises back to 0. It is never positive.
- R4: The triangle phase advances one step every STEP_DIV reference cycles, where STEP_DIV = max(1, (MOD_PERIOD_CYC + DEPTH_LO) / (2*DEPTH_LO)). A period is 2*DEPTH_LO steps for both depths. Each step moves the code by 1 (shallow) or 2 (deep). The first step is taken STEP_DIV edges after the first edge that sees modulation running.
- R5: While `mod_en` is low, `offset_code` is 0 in the same cycle, and the phase returns to the period start.
- R6: While `pwr_dn_n` is low, `offset_code` and `clk_out_en` are 0 in the same cycle and `ready` is 0 after the next edge. After release, `clk_out_en` rises after one edge and the triangle restarts from its start point.
- R7: After power-down release, or after reset release with stable pins, `ready` is 0 for SETTLE_CYC-1 edges and 1 after SETTLE_CYC edges.
- R8: A change on `deep_sel` or `mod_en` clears `ready` at the next edge. `ready` returns after SETTLE_CYC further edges. A change on `center_sel` alone leaves `ready` unchanged.
- R9: `center_sel` and `deep_sel` are taken into the triangle only at the wrap from the last step to step 0, or while modulation is not running. A change in mid-period has no effect on the code until the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| center_sel | input | 1 | 1 = centered triangle, 0 = downward triangle |
| deep_sel | input | 1 | 0 = shallow depth, 1 = deep (double) depth |
| mod_en | input | 1 | Modulation enable, active high |
| pwr_dn_n | input | 1 | Power-down, active low |
| offset_code | output | CODE_W | Signed frequency offset, 0.01 % per LSB |
| clk_out_en | output | 1 | Clock output enable; 0 forces the synthesizer outputs low |
| ready | output | 1 | Settling wait complete |

## Verification
The period wrap and a depth-pin change can land on the same edge. On that edge the new depth must be latched for the coming period, and the settling wait must restart. The bench provokes this by starting a downward triangle and flipping `deep_sel` one edge before the wrap. It then judges that the code is 0 with `ready` cleared on the wrap edge, and that the first step of the new period already has the deep step size. A second case flips the depth in mid-ramp, where the code must keep its shallow slope until the next period starts.

// File: rtl/ssc_tri_mod.sv
module ssc_tri_mod #(
  parameter int DEPTH_LO       = 100,
  parameter int MOD_PERIOD_CYC = 740,
  parameter int SETTLE_CYC     = 120000,
  localparam int STEPS    = 2 * DEPTH_LO,
  localparam int HALF     = DEPTH_LO / 2,
  localparam int DIV_RAW  = (MOD_PERIOD_CYC + DEPTH_LO) / STEPS,
  localparam int STEP_DIV = (DIV_RAW < 1) ? 1 : DIV_RAW,
  localparam int DIV_W    = $clog2(STEP_DIV + 1),
  localparam int PH_W     = $clog2(STEPS),
  localparam int SET_W    = $clog2(SETTLE_CYC + 1),
  localparam int CODE_W   = $clog2(2 * DEPTH_LO + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     center_sel,
  input  logic                     deep_sel,
  input  logic                     mod_en,
  input  logic                     pwr_dn_n,
  output logic signed [CODE_W-1:0] offset_code,
  output logic                     clk_out_en,
  output logic                     ready
);

  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  ph_q;
  logic [SET_W-1:0] settle_q;
  logic             cen_q, deep_l_q;
  logic             deep_q, en_q, run_q;
  int               base, tri_val;

  wire run        = mod_en & pwr_dn_n;
  wire step       = (div_q == DIV_W'(STEP_DIV - 1));
  wire wrap       = step && (ph_q == PH_W'(STEPS - 1));
  wire cfg_change = (deep_sel != deep_q) || (mod_en != en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      ph_q     <= '0;
      settle_q <= '0;
      cen_q    <= 1'b0;
      deep_l_q <= 1'b0;
      deep_q   <= 1'b0;
      en_q     <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      deep_q <= deep_sel;
      en_q   <= mod_en;
      run_q  <= pwr_dn_n;
      if (!run) begin
        div_q    <= '0;
        ph_q     <= '0;
        cen_q    <= center_sel;
        deep_l_q <= deep_sel;
      end else begin
        div_q <= step ? '0 : div_q + 1'b1;
        if (step) ph_q <= wrap ? '0 : ph_q + 1'b1;
        if (wrap) begin
          cen_q    <= center_sel;
          deep_l_q <= deep_sel;
        end
      end
      if (!pwr_dn_n || cfg_change) settle_q <= '0;
      else if (!ready)             settle_q <= settle_q + 1'b1;
    end
  end

  always_comb begin
    int p;
    p = int'(ph_q);
    if (cen_q) begin
      if (p < HALF)          base = p;
      else if (p < 3 * HALF) base = DEPTH_LO - p;
      else                   base = p - STEPS;
    end else begin
      if (p <= DEPTH_LO) base = -p;
      else               base = p - STEPS;
    end
    tri_val = deep_l_q ? 2 * base : base;
  end

  assign offset_code = run ? CODE_W'(tri_val) : '0;
  assign clk_out_en  = pwr_dn_n & run_q;
  assign ready       = (settle_q == SET_W'(SETTLE_CYC));

  assert_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_code <= DEPTH_LO) && (offset_code >= -2 * DEPTH_LO));

  assert_down_nonpos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cen_q |-> (offset_code <= 0));

  assert_step_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |->
      ((int'(offset_code) - int'($past(offset_code)) <= 2) &&
       (int'(offset_code) - int'($past(offset_code)) >= -2)));

  assert_idle_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (ph_q == '0));

  assert_pd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |=> (!ready && !run_q && ph_q == '0));

  assert_settle_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_sel != deep_q || mod_en != en_q) |=> !ready);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != '0) |-> ($stable(cen_q) && $stable(deep_l_q)));

endmodule

// File: tb/ssc_tri_mod_tb.sv
module ssc_tri_mod_tb;
  localparam int DEPTH_LO = 8;
  localparam int PERIOD   = 32;
  localparam int SETTLE   = 20;
  localparam int CW       = $clog2(2 * DEPTH_LO + 1) + 1;
  localparam int NV       = 14;
  localparam int VEC [NV][4] = '{
    '{1,0,0,0},  '{1,0,8,4},  '{1,0,9,4},   '{1,0,12,2},  '{1,0,24,-4},
    '{1,0,30,-1},'{1,0,32,0}, '{1,1,8,8},   '{1,1,24,-8}, '{0,0,16,-8},
    '{0,0,18,-7},'{0,0,31,-1},'{0,1,16,-16},'{0,1,6,-6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic center_sel = 1'b0, deep_sel = 1'b0, mod_en = 1'b0, pwr_dn_n = 1'b1;
  logic signed [CW-1:0] offset_code;
  logic clk_out_en, ready;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ssc_tri_mod #(.DEPTH_LO(DEPTH_LO), .MOD_PERIOD_CYC(PERIOD), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .center_sel(center_sel), .deep_sel(deep_sel),
    .mod_en(mod_en), .pwr_dn_n(pwr_dn_n), .offset_code(offset_code),
    .clk_out_en(clk_out_en), .ready(ready));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic restart(input logic c, input logic d);
    @(negedge clk);
    mod_en = 1'b0; center_sel = c; deep_sel = d;
    @(negedge clk);
    mod_en = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    edges(3);
    chk("R1", "code in reset", int'(offset_code), 0);
    chk("R1", "ready in reset", int'(ready), 0);
    chk("R1", "out_en in reset", int'(clk_out_en), 0);
    @(negedge clk); rst_n = 1'b1;
    edges(1);
    chk("R6", "out_en after reset", int'(clk_out_en), 1);
    edges(SETTLE - 2);
    chk("R7", "ready before wait", int'(ready), 0);
    edges(1);
    chk("R7", "ready after wait", int'(ready), 1);

    for (int i = 0; i < NV; i++) begin
      restart(VEC[i][0][0], VEC[i][1][0]);
      edges(VEC[i][2]);
      chk(VEC[i][0] != 0 ? "R2" : "R3", $sformatf("vector %0d code", i), int'(offset_code), VEC[i][3]);
    end

    // R9: mid-ramp depth change waits for the period start
    restart(1'b1, 1'b0);
    edges(12);
    chk("R4", "shallow ramp", int'(offset_code), 2);
    deep_sel = 1'b1;
    edges(2);
    chk("R9", "mid-period change ignored", int'(offset_code), 1);
    edges(18);
    chk("R9", "period start", int'(offset_code), 0);
    edges(8);
    chk("R9", "deep slope next period", int'(offset_code), 8);

    // concurrent: depth flip lands on the wrap edge
    restart(1'b0, 1'b0);
    edges(31);
    chk("R3", "last step of period", int'(offset_code), -1);
    deep_sel = 1'b1;
    edges(1);
    chk("R9", "wrap code", int'(offset_code), 0);
    chk("R8", "ready cleared at wrap", int'(ready), 0);
    edges(2);
    chk("R9", "deep first step", int'(offset_code), -2);
    edges(SETTLE - 3);
    chk("R8", "ready still low", int'(ready), 0);
    edges(1);
    chk("R8", "ready back", int'(ready), 1);

    // power-down
    restart(1'b1, 1'b0);
    edges(10);
    chk("R2", "before power-down", int'(offset_code), 3);
    pwr_dn_n = 1'b0;
    #1;
    chk("R6", "code in power-down", int'(offset_code), 0);
    chk("R6", "out_en in power-down", int'(clk_out_en), 0);
    edges(3);
    chk("R6", "ready in power-down", int'(ready), 0);
    pwr_dn_n = 1'b1;
    #1;
    chk("R6", "out_en same cycle as release", int'(clk_out_en), 0);
    edges(1);
    chk("R6", "out_en after release", int'(clk_out_en), 1);
    edges(7);
    chk("R6", "phase restarted", int'(offset_code), 4);
    edges(SETTLE - 9);
    chk("R7", "ready before wait", int'(ready), 0);
    edges(1);
    chk("R7", "ready after wait", int'(ready), 1);

    // modulation enable
    center_sel = 1'b1; deep_sel = 1'b1;
    edges(SETTLE + 40);
    mod_en = 1'b0;
    #1;
    chk("R5", "code when disabled", int'(offset_code), 0);
    edges(1);
    chk("R8", "ready after enable change", int'(ready), 0);
    edges(10);
    chk("R5", "code stays zero", int'(offset_code), 0);
    mod_en = 1'b1;
    edges(2);
    chk("R5", "restart from start", int'(offset_code), 2);
    edges(SETTLE + 2);
    chk("R8", "ready restored", int'(ready), 1);
    center_sel = 1'b0;
    edges(2);
    chk("R8", "mode change keeps ready", int'(ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule